// File: doc/BRIEF.md
# AXI-Lite to Register Strobe Adapter

This block sits between a single-beat AXI-Lite subordinate port and a peripheral's register file. It merges the five split AXI channels into one register-side access. That access is a single-cycle write enable or read enable, together with an address, write data and byte enables. The register file answers in that same cycle with read data and an error flag. The adapter folds these into the B or R response.

Only one access is handled at a time. All AXI ready outputs stay low from the moment an access is accepted until its response has been taken. Because of this, each register-side result belongs to exactly one AXI response. A write is accepted only when AW and W are both valid. A complete write request takes priority over a read request. An address that is not word-aligned never reaches the register file and gets an error response.

Top module: `axil_reg_adapter`

## Requirements
- R1: After reset is released, reg_we_o, reg_re_o, bvalid_o and rvalid_o are all low.
- R2: In idle, when awvalid_i and wvalid_i are both high, awready_o and wready_o go high together in that cycle. In the next cycle, reg_we_o is high for exactly one cycle, carrying the accepted address, write data and write strobes.
- R3: bvalid_o rises in the cycle after the write-access cycle and stays high, with bresp_o stable, until bready_i is seen high.
- R4: In idle, with arvalid_i high and no complete write pending, arready_o goes high. In the next cycle, reg_re_o is high for exactly one cycle with the accepted address and all byte enables set. rvalid_o rises the cycle after that, with the captured data. It stays high, with rdata_o and rresp_o stable, until rready_i.
- R5: awready_o, wready_o and arready_o are low whenever an access or response is in progress (strobe high or bvalid_o/rvalid_o high).
- R6: If reg_err_i is high in the access cycle, the very next response carries SLVERR (2'b10) and rdata_o is zero. Otherwise the response code is OKAY (2'b00).
- R7: If AW, W and AR are all valid in idle, the write is accepted first. arready_o stays low until the B response has been accepted.
- R8: An address with any of its low log2(DATA_W/8) bits set gets an SLVERR response after the normal latency. No register strobe is asserted for it, so the register contents are left unchanged.
- R9: An AW beat without a W beat (or W without AW) does not start a write and leaves awready_o and wready_o low. A read request is served meanwhile.
- R10: At most one of reg_we_o, reg_re_o, bvalid_o and rvalid_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| awaddr_i | input | ADDR_W | Write address |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| wdata_i | input | DATA_W | Write data |
| wstrb_i | input | DATA_W/8 | Write byte strobes |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| bresp_o | output | 2 | Write response code |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| araddr_i | input | ADDR_W | Read address |
| rvalid_o | output | 1 | Read response valid |
| rready_i | input | 1 | Read response ready |
| rdata_o | output | DATA_W | Read data |
| rresp_o | output | 2 | Read response code |
| reg_we_o | output | 1 | Register write enable, one cycle |
| reg_re_o | output | 1 | Register read enable, one cycle |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_be_o | output | DATA_W/8 | Register byte enables |
| reg_rdata_i | input | DATA_W | Register read data, same cycle as the enable |
| reg_err_i | input | 1 | Register error flag, same cycle as the enable |

## Verification
The assertions assume that the register file answers combinationally: reg_rdata_i and reg_err_i must be valid in the very cycle the enable is high. They also assume that a manager holds its valid and payload stable until the matching ready arrives. The bench's register model decodes the address combinationally and flags every address at or above 0x40 as an error. Its directed tasks raise valid and payload only on falling edges and hold them until the ready has been observed. Ready-back-pressure on B and R is exercised by holding bready_i or rready_i low for a cycle before accepting.

// File: rtl/axil_reg_pkg.sv
package axil_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WR   = 3'd1,
    ST_RD   = 3'd2,
    ST_B    = 3'd3,
    ST_R    = 3'd4
  } state_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/axil_reg_fsm.sv
module axil_reg_fsm
  import axil_reg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   awvalid_i,
  input  logic   wvalid_i,
  input  logic   arvalid_i,
  input  logic   bready_i,
  input  logic   rready_i,
  output state_e state_o,
  output logic   awready_o,
  output logic   wready_o,
  output logic   arready_o
);
  state_e state_q, state_d;
  logic   wr_pend, idle;

  assign wr_pend   = awvalid_i & wvalid_i;
  assign idle      = (state_q == ST_IDLE);
  assign awready_o = idle & wr_pend;
  assign wready_o  = idle & wr_pend;
  // write wins over read
  assign arready_o = idle & ~wr_pend & arvalid_i;
  assign state_o   = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_pend)        state_d = ST_WR;
        else if (arvalid_i) state_d = ST_RD;
      end
      ST_WR:   state_d = ST_B;
      ST_RD:   state_d = ST_R;
      ST_B:    if (bready_i) state_d = ST_IDLE;
      ST_R:    if (rready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  a_r9_no_half_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awready_o || wready_o) |-> (awvalid_i && wvalid_i));
  a_r7_write_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awvalid_i && wvalid_i && arvalid_i) |-> !arready_o);
  a_r2_ready_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awready_o |=> (state_q == ST_WR));
endmodule

// File: rtl/axil_reg_req.sv
module axil_reg_req
  import axil_reg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  state_e              state_i,
  input  logic                take_wr_i,
  input  logic                take_rd_i,
  input  logic [ADDR_W-1:0]   awaddr_i,
  input  logic [ADDR_W-1:0]   araddr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] wstrb_i,
  output logic                reg_we_o,
  output logic                reg_re_o,
  output logic [ADDR_W-1:0]   reg_addr_o,
  output logic [DATA_W-1:0]   reg_wdata_o,
  output logic [DATA_W/8-1:0] reg_be_o,
  output logic                misalign_o
);
  localparam int              STRB_W   = DATA_W / 8;
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(STRB_W - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [STRB_W-1:0] be_q;
  logic              bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      bad_q   <= 1'b0;
    end else if (take_wr_i) begin
      addr_q  <= awaddr_i;
      wdata_q <= wdata_i;
      be_q    <= wstrb_i;
      bad_q   <= |(awaddr_i & OFS_MASK);
    end else if (take_rd_i) begin
      addr_q  <= araddr_i;
      wdata_q <= '0;
      be_q    <= '1;
      bad_q   <= |(araddr_i & OFS_MASK);
    end
  end

  // misaligned accesses never reach the register file
  assign reg_we_o    = (state_i == ST_WR) & ~bad_q;
  assign reg_re_o    = (state_i == ST_RD) & ~bad_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_be_o    = be_q;
  assign misalign_o  = bad_q;

  a_r2_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  a_r4_re_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);
  a_r8_no_strobe_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |-> ((reg_addr_o & OFS_MASK) == '0));
  a_r4_read_all_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |-> (reg_be_o == '1));
endmodule

// File: rtl/axil_reg_resp.sv
module axil_reg_resp
  import axil_reg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            state_i,
  input  logic              misalign_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              reg_err_i,
  input  logic              bready_i,
  input  logic              rready_i,
  output logic              bvalid_o,
  output logic [1:0]        bresp_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o
);
  logic              fail;
  logic [1:0]        bresp_q, rresp_q;
  logic [DATA_W-1:0] rdata_q;

  assign fail = misalign_i | reg_err_i;

  // sampled in the access cycle itself: no extra delay on errors
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bresp_q <= RESP_OKAY;
      rresp_q <= RESP_OKAY;
      rdata_q <= '0;
    end else if (state_i == ST_WR) begin
      bresp_q <= fail ? RESP_SLVERR : RESP_OKAY;
    end else if (state_i == ST_RD) begin
      rresp_q <= fail ? RESP_SLVERR : RESP_OKAY;
      rdata_q <= fail ? '0 : reg_rdata_i;
    end
  end

  assign bvalid_o = (state_i == ST_B);
  assign rvalid_o = (state_i == ST_R);
  assign bresp_o  = bresp_q;
  assign rresp_o  = rresp_q;
  assign rdata_o  = rdata_q;

  a_r3_b_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bvalid_o && !bready_i) |=> (bvalid_o && $stable(bresp_o)));
  a_r4_r_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rdata_o) && $stable(rresp_o)));
  a_r6_wr_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_WR) && reg_err_i) |=> (bvalid_o && bresp_o == RESP_SLVERR));
  a_r6_rd_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_RD) && reg_err_i) |=>
      (rvalid_o && rresp_o == RESP_SLVERR && rdata_o == '0));
  a_r8_misalign_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_WR) && misalign_i) |=> (bresp_o == RESP_SLVERR));
endmodule

// File: rtl/axil_reg_adapter.sv
module axil_reg_adapter
  import axil_reg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                awvalid_i,
  output logic                awready_o,
  input  logic [ADDR_W-1:0]   awaddr_i,
  input  logic                wvalid_i,
  output logic                wready_o,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] wstrb_i,
  output logic                bvalid_o,
  input  logic                bready_i,
  output logic [1:0]          bresp_o,
  input  logic                arvalid_i,
  output logic                arready_o,
  input  logic [ADDR_W-1:0]   araddr_i,
  output logic                rvalid_o,
  input  logic                rready_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [1:0]          rresp_o,
  output logic                reg_we_o,
  output logic                reg_re_o,
  output logic [ADDR_W-1:0]   reg_addr_o,
  output logic [DATA_W-1:0]   reg_wdata_o,
  output logic [DATA_W/8-1:0] reg_be_o,
  input  logic [DATA_W-1:0]   reg_rdata_i,
  input  logic                reg_err_i
);
  state_e state;
  logic   misalign;

  axil_reg_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .awvalid_i (awvalid_i),
    .wvalid_i  (wvalid_i),
    .arvalid_i (arvalid_i),
    .bready_i  (bready_i),
    .rready_i  (rready_i),
    .state_o   (state),
    .awready_o (awready_o),
    .wready_o  (wready_o),
    .arready_o (arready_o)
  );

  axil_reg_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .take_wr_i   (awready_o),
    .take_rd_i   (arready_o),
    .awaddr_i    (awaddr_i),
    .araddr_i    (araddr_i),
    .wdata_i     (wdata_i),
    .wstrb_i     (wstrb_i),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_be_o    (reg_be_o),
    .misalign_o  (misalign)
  );

  axil_reg_resp #(.DATA_W(DATA_W)) u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .misalign_i  (misalign),
    .reg_rdata_i (reg_rdata_i),
    .reg_err_i   (reg_err_i),
    .bready_i    (bready_i),
    .rready_i    (rready_i),
    .bvalid_o    (bvalid_o),
    .bresp_o     (bresp_o),
    .rvalid_o    (rvalid_o),
    .rdata_o     (rdata_o),
    .rresp_o     (rresp_o)
  );

  a_r10_one_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, reg_re_o, bvalid_o, rvalid_o}));
  a_r5_ready_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o || bvalid_o || rvalid_o) |->
      (!awready_o && !wready_o && !arready_o));
  a_r3_b_after_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> bvalid_o);
  a_r4_r_after_re: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> rvalid_o);
  a_r1_quiet_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!reg_we_o && !reg_re_o && !bvalid_o && !rvalid_o));
endmodule

// File: tb/axil_reg_adapter_bench.sv
`timescale 1ns/1ps
module axil_reg_adapter_bench;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int SW = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          awvalid = 0, wvalid = 0, arvalid = 0, bready = 0, rready = 0;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic [DW-1:0] wdata = '0;
  logic [SW-1:0] wstrb = '0;
  logic          awready, wready, arready, bvalid, rvalid;
  logic [1:0]    bresp, rresp;
  logic [DW-1:0] rdata;
  logic          reg_we, reg_re, reg_err;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [SW-1:0] reg_be;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  axil_reg_adapter #(.ADDR_W(AW), .DATA_W(DW)) u_axil_reg_adapter (
    .clk_i(clk), .rst_ni(rst_n),
    .awvalid_i(awvalid), .awready_o(awready), .awaddr_i(awaddr),
    .wvalid_i(wvalid), .wready_o(wready), .wdata_i(wdata), .wstrb_i(wstrb),
    .bvalid_o(bvalid), .bready_i(bready), .bresp_o(bresp),
    .arvalid_i(arvalid), .arready_o(arready), .araddr_i(araddr),
    .rvalid_o(rvalid), .rready_i(rready), .rdata_o(rdata), .rresp_o(rresp),
    .reg_we_o(reg_we), .reg_re_o(reg_re), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_be_o(reg_be),
    .reg_rdata_i(reg_rdata), .reg_err_i(reg_err)
  );

  // register file model: 16 words, error at or above 0x40
  logic [DW-1:0] mem [16];
  assign reg_err   = (reg_addr >= AW'(64));
  assign reg_rdata = reg_err ? 32'hDEAD_BEEF : mem[reg_addr[5:2]];
  always @(posedge clk) begin
    if (reg_we && !reg_err)
      for (int b = 0; b < SW; b++)
        if (reg_be[b]) mem[reg_addr[5:2]][8*b +: 8] <= reg_wdata[8*b +: 8];
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_code(input logic [AW-1:0] a);
    return ((a[1:0] != 2'b00) || (a >= AW'(64))) ? 2'b10 : 2'b00;
  endfunction

  // full write; expect_we tells whether the strobe must fire
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [SW-1:0] s, input logic expect_we);
    @(negedge clk);
    awvalid = 1; awaddr = a; wvalid = 1; wdata = d; wstrb = s;
    #1 chk("R2 aw/w ready pair", {awready, wready}, 2'b11);
    @(negedge clk);
    chk("R2/R8 write strobe", reg_we, expect_we);
    if (expect_we) begin
      chk("R2 strobe addr", reg_addr, a);
      chk("R2 strobe data", reg_wdata, d);
      chk("R2 strobe be", reg_be, s);
    end
    awvalid = 0; wvalid = 0;
    @(negedge clk);
    chk("R3 bvalid", bvalid, 1);
    chk("R6/R8 bresp", bresp, exp_code(a));
    chk("R2 strobe single", reg_we, 0);
    awvalid = 1; wvalid = 1;
    #1 chk("R5 ready low in B", {awready, wready, arready}, 3'b000);
    awvalid = 0; wvalid = 0;
    @(negedge clk);
    chk("R3 bvalid hold", bvalid, 1);
    chk("R3 bresp hold", bresp, exp_code(a));
    bready = 1;
    @(negedge clk);
    chk("R3 bvalid drop", bvalid, 0);
    bready = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic expect_re,
                         input logic [DW-1:0] exp_d);
    @(negedge clk);
    arvalid = 1; araddr = a;
    #1 chk("R4 arready", arready, 1);
    @(negedge clk);
    chk("R4/R8 read strobe", reg_re, expect_re);
    if (expect_re) begin
      chk("R4 strobe addr", reg_addr, a);
      chk("R4 read be all", reg_be, {SW{1'b1}});
    end
    arvalid = 0;
    @(negedge clk);
    chk("R4 rvalid", rvalid, 1);
    chk("R4/R6 rdata", rdata, exp_d);
    chk("R6/R8 rresp", rresp, exp_code(a));
    chk("R4 strobe single", reg_re, 0);
    arvalid = 1;
    #1 chk("R5 arready low in R", arready, 0);
    arvalid = 0;
    @(negedge clk);
    chk("R4 rvalid hold", rvalid, 1);
    chk("R4 rdata hold", rdata, exp_d);
    rready = 1;
    @(negedge clk);
    chk("R4 rvalid drop", rvalid, 0);
    rready = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset strobes/valids", {reg_we, reg_re, bvalid, rvalid}, 4'b0000);
  endtask

  task automatic t_byte_strobe;
    do_write(12'h008, 32'hAABB_CCDD, 4'b1111, 1);
    do_write(12'h008, 32'h1122_3344, 4'b0101, 1);
    do_read(12'h008, 1, 32'hAA22_CC44);
  endtask

  task automatic t_misaligned;
    do_write(12'h004, 32'h1234_5678, 4'b1111, 1);
    do_write(12'h006, 32'hFFFF_FFFF, 4'b1111, 0);
    do_read(12'h004, 1, 32'h1234_5678);  // R8 contents unchanged
    do_read(12'h005, 0, 32'h0);
  endtask

  task automatic t_reg_error;
    do_write(12'h100, 32'h0BAD_0BAD, 4'b1111, 1);
    do_read(12'h100, 1, 32'h0);  // R6 zero data on error
  endtask

  task automatic t_priority;
    @(negedge clk);
    awvalid = 1; awaddr = 12'h010; wvalid = 1; wdata = 32'hCAFE_F00D; wstrb = 4'hF;
    arvalid = 1; araddr = 12'h010;
    #1 chk("R7 write accepted first", {awready, arready}, 2'b10);
    @(negedge clk);
    chk("R7 write strobe", reg_we, 1);
    awvalid = 0; wvalid = 0;
    @(negedge clk);
    chk("R7 arready waits for B", {bvalid, arready}, 2'b10);
    bready = 1;
    @(negedge clk);
    bready = 0;
    chk("R7 arready after B", arready, 1);
    @(negedge clk);
    chk("R7 read strobe", reg_re, 1);
    arvalid = 0;
    @(negedge clk);
    chk("R7 read sees write", rdata, 32'hCAFE_F00D);
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  task automatic t_aw_only;
    @(negedge clk);
    awvalid = 1; awaddr = 12'h020; wvalid = 0; wdata = 32'h0000_0055; wstrb = 4'hF;
    arvalid = 1; araddr = 12'h008;
    #1 chk("R9 no ready on lone AW", {awready, wready, arready}, 3'b001);
    @(negedge clk);
    chk("R9 read served", reg_re, 1);
    arvalid = 0;
    @(negedge clk);
    chk("R9 read data", rdata, 32'hAA22_CC44);
    rready = 1;
    @(negedge clk);
    rready = 0;
    chk("R9 still waiting for W", {awready, wready, reg_we}, 3'b000);
    wvalid = 1;
    #1 chk("R9 pair completes", {awready, wready}, 2'b11);
    @(negedge clk);
    chk("R9 write strobe", reg_we, 1);
    awvalid = 0; wvalid = 0;
    @(negedge clk);
    chk("R9 bresp", {bvalid, bresp}, 3'b100);
    bready = 1;
    @(negedge clk);
    bready = 0;
    do_read(12'h020, 1, 32'h0000_0055);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    t_reset;
    t_byte_strobe;
    t_misaligned;
    t_reg_error;
    t_priority;
    t_aw_only;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run;
  end
endmodule